// File: doc/BRIEF.md
# 64-bit Interval Timer with Atomic Counter Read

This block is a memory-mapped interval timer with a 64-bit up-counter. It sits on a simple register bus with an address, write data, a write strobe, a read strobe and registered read data. The counter advances on each tick of the selected source, after a programmable divider. That source is either the bus clock itself or a slow external clock. The slow clock is brought into the bus domain through a synchronizer and an edge detector.

The counter counts from zero up to a programmed 64-bit period. On the next advance it returns to zero and raises a pending flag. The flag drives a maskable interrupt and is cleared by reading the status register. In continuous mode the counter keeps running after the match. In single-shot mode it stops at the match. Reading the low half of the counter captures the high half, so a 64-bit value read as two 32-bit words is always consistent.

Top module: `interval64_timer`

## Requirements
- R1: After reset, reads return zero from the control register (offset 0x00), the mode register (0x04), the interrupt-enable register (0x10), the status register (0x1C), the counter low word (0x20) and any unmapped offset such as 0x14. Both period words (0x08, 0x0C) read all ones, and the interrupt output is low. Read data appears on the cycle after the read strobe.
- R2: Writing control bit 0 sets the running state, which reads back in control bit 0. With mode bit 3 clear and a divider of 0, the counter then advances by one per bus clock.
- R3: Mode bits 11:8 hold a divider value p from 0 to 15. The counter advances once every p+1 source ticks.
- R4: With mode bit 0 set (continuous), an advance while the counter equals the period returns the counter to zero and sets the pending flag. The timer keeps running.
- R5: With mode bit 0 clear (single-shot), the same advance returns the counter to zero, sets the pending flag and clears the running state. A new start write runs the timer again from zero.
- R6: A write to the period low word (0x08) loads the match value from the staged high word (0x0C) and the written low word. A write to the high word alone does not change the match value. Both words read back as written.
- R7: A read of the counter low word (0x20) captures the counter's high word. A later read of 0x24 returns that captured value, however many cycles have passed.
- R8: A status read (0x1C) returns the pending flag in bit 0 and clears the flag. If a match event falls in the same cycle as the read, the flag stays set.
- R9: The interrupt output equals the pending flag ANDed with interrupt-enable bit 0 (offset 0x10).
- R10: With mode bit 3 set, the counter advances once per rising edge of the slow clock input, taken after a two-stage synchronizer and an edge detector. Bus clock cycles alone do not advance it.
- R11: Writing control bit 8 stops the timer and clears the counter, the pending flag, the captured high word, the mode and the interrupt enable. It also sets both period words and the match value back to all ones. This takes precedence over bit 0 in the same write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_clk_in | input | 1 | Slow count source, asynchronous, at most one third of the bus clock rate |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| irq | output | 1 | Period-match interrupt |

## Verification
The assertions check the following on every cycle:
- The counter holds when it does not advance.
- It steps by exactly one below the period.
- A match event returns it to zero and sets the pending flag.
- The running state either survives the match or drops, according to the mode.
- A status read without a simultaneous event clears the flag.
- A software reset leaves the block idle.

Some behaviour shows only through the bench's scenarios: the decoded register offsets and bit positions, the divider ratio, the staging of the period high word, the high-word capture across a long gap, the slow-clock edge count through the synchronizer, and the interrupt masking.

// File: rtl/it64_pkg.sv
package it64_pkg;
  localparam int ADDR_W = 6;
  localparam int DIV_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_MODE   = 6'h04;
  localparam logic [ADDR_W-1:0] A_PER_LO = 6'h08;
  localparam logic [ADDR_W-1:0] A_PER_HI = 6'h0C;
  localparam logic [ADDR_W-1:0] A_IEN    = 6'h10;
  localparam logic [ADDR_W-1:0] A_STAT   = 6'h1C;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 6'h20;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h24;

  localparam int B_START  = 0;
  localparam int B_SWRST  = 8;
  localparam int B_CONT   = 0;
  localparam int B_SLOW   = 3;
  localparam int B_DIV_LO = 8;
  localparam int B_IEN    = 0;
  localparam int B_PEND   = 0;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic             slow;
    logic             cont;
  } mode_cfg_t;
endpackage

// File: rtl/it64_slow_edge.sv
module it64_slow_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int TOTAL = SYNC_STAGES + 1;

  logic [TOTAL-1:0] stage_q;
  logic [TOTAL-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[TOTAL-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  // edge detector sits after the last synchronizer stage
  assign rise = stage_q[SYNC_STAGES-1] & ~stage_q[SYNC_STAGES];
endmodule

// File: rtl/it64_prescaler.sv
module it64_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [DIV_W-1:0] div,
  output logic             adv
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] phase_d;
  logic             last;

  // >= keeps the phase bounded if the divider is lowered mid-run
  assign last = tick && (phase_q >= div);

  always_comb begin
    phase_d = phase_q;
    if (clr) begin
      phase_d = '0;
    end else if (tick) begin
      phase_d = last ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

  assign adv = last & ~clr;
endmodule

// File: rtl/it64_count_core.sv
module it64_count_core #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic             adv,
  input  logic             cont,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             match_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             run_q;
  logic             run_d;
  logic             at_top;

  assign at_top    = (cnt_q == period);
  assign match_evt = adv & at_top & ~clr;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    if (clr) begin
      cnt_d = '0;
      run_d = 1'b0;
    end else begin
      if (start) begin
        run_d = 1'b1;
      end
      if (adv) begin
        if (at_top) begin
          cnt_d = '0;
          if (!cont) begin
            run_d = 1'b0;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign count   = cnt_q;
  assign running = run_q;
endmodule

// File: rtl/interval64_timer.sv
module interval64_timer
  import it64_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_clk_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  // decoded strobes
  logic wr_ctrl, wr_mode, wr_plo, wr_phi, wr_ien;
  logic rd_stat, rd_clo;
  logic swrst, start;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign wr_mode = bus_we && (bus_addr == A_MODE);
  assign wr_plo  = bus_we && (bus_addr == A_PER_LO);
  assign wr_phi  = bus_we && (bus_addr == A_PER_HI);
  assign wr_ien  = bus_we && (bus_addr == A_IEN);
  assign rd_stat = bus_re && (bus_addr == A_STAT);
  assign rd_clo  = bus_re && (bus_addr == A_CNT_LO);
  assign swrst   = wr_ctrl && bus_wdata[B_SWRST];
  assign start   = wr_ctrl && bus_wdata[B_START] && !bus_wdata[B_SWRST];

  // configuration and status state
  mode_cfg_t        mode_q, mode_d;
  logic [DATA_W-1:0] plo_q, plo_d;
  logic [DATA_W-1:0] phi_q, phi_d;
  logic [CNT_W-1:0]  shadow_q, shadow_d;
  logic              ien_q, ien_d;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  // datapath links
  logic             slow_rise;
  logic             src_tick;
  logic             adv;
  logic             running;
  logic             match_evt;
  logic [CNT_W-1:0] count;
  logic             mode_cont;

  assign mode_cont = mode_q.cont;

  it64_slow_edge #(.SYNC_STAGES(SYNC_STAGES)) u_slow (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (slow_clk_in),
    .rise     (slow_rise)
  );

  assign src_tick = mode_q.slow ? slow_rise : 1'b1;

  it64_prescaler #(.DIV_W(DIV_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (swrst),
    .tick  (running & src_tick),
    .div   (mode_q.div),
    .adv   (adv)
  );

  it64_count_core #(.CNT_W(CNT_W)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (swrst),
    .start     (start),
    .adv       (adv),
    .cont      (mode_q.cont),
    .period    (shadow_q),
    .count     (count),
    .running   (running),
    .match_evt (match_evt)
  );

  // next-state for configuration
  always_comb begin
    mode_d   = mode_q;
    plo_d    = plo_q;
    phi_d    = phi_q;
    shadow_d = shadow_q;
    ien_d    = ien_q;
    if (swrst) begin
      mode_d   = '0;
      plo_d    = '1;
      phi_d    = '1;
      shadow_d = '1;
      ien_d    = 1'b0;
    end else begin
      if (wr_mode) begin
        mode_d.cont = bus_wdata[B_CONT];
        mode_d.slow = bus_wdata[B_SLOW];
        mode_d.div  = bus_wdata[B_DIV_LO +: DIV_W];
      end
      if (wr_phi) begin
        phi_d = bus_wdata;
      end
      if (wr_plo) begin
        plo_d    = bus_wdata;
        shadow_d = {phi_q, bus_wdata};
      end
      if (wr_ien) begin
        ien_d = bus_wdata[B_IEN];
      end
    end
  end

  // next-state for pending flag and captured high word
  always_comb begin
    pend_d = pend_q;
    hold_d = hold_q;
    if (swrst) begin
      pend_d = 1'b0;
      hold_d = '0;
    end else begin
      if (match_evt) begin
        pend_d = 1'b1;
      end else if (rd_stat) begin
        pend_d = 1'b0;
      end
      if (rd_clo) begin
        hold_d = count[CNT_W-1:DATA_W];
      end
    end
  end

  // read multiplexer
  always_comb begin
    logic [DATA_W-1:0] mux;
    mux = '0;
    unique case (bus_addr)
      A_CTRL:   mux[B_START] = running;
      A_MODE: begin
        mux[B_CONT]              = mode_q.cont;
        mux[B_SLOW]              = mode_q.slow;
        mux[B_DIV_LO +: DIV_W]   = mode_q.div;
      end
      A_PER_LO: mux = plo_q;
      A_PER_HI: mux = phi_q;
      A_IEN:    mux[B_IEN] = ien_q;
      A_STAT:   mux[B_PEND] = pend_q;
      A_CNT_LO: mux = count[DATA_W-1:0];
      A_CNT_HI: mux = hold_q;
      default:  mux = '0;
    endcase
    rdata_d = bus_re ? mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      plo_q    <= '1;
      phi_q    <= '1;
      shadow_q <= '1;
      ien_q    <= 1'b0;
      pend_q   <= 1'b0;
      hold_q   <= '0;
      rdata_q  <= '0;
    end else begin
      mode_q   <= mode_d;
      plo_q    <= plo_d;
      phi_q    <= phi_d;
      shadow_q <= shadow_d;
      ien_q    <= ien_d;
      pend_q   <= pend_d;
      hold_q   <= hold_d;
      rdata_q  <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = pend_q & ien_q;
endmodule

// File: rtl/it64_checker.sv
module it64_checker #(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             adv,
  input logic             clr,
  input logic             match_evt,
  input logic             stat_rd,
  input logic             running,
  input logic             cont,
  input logic             pending,
  input logic             ien,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] period
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(count));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && (count != period)) |=> (count == $past(count) + ONE));

  p_adv_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> running);

  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> ((count == '0) && pending));

  p_cont_runs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && cont) |=> running);

  p_oneshot_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cont) |=> !running);

  p_stat_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !match_evt && !clr) |=> !pending);

  p_swrst_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ((count == '0) && !running && !pending && !ien));
endmodule

bind interval64_timer it64_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .adv       (adv),
  .clr       (swrst),
  .match_evt (match_evt),
  .stat_rd   (rd_stat),
  .running   (running),
  .cont      (mode_cont),
  .pending   (pend_q),
  .ien       (ien_q),
  .count     (count),
  .period    (shadow_q)
);

// File: tb/tb_interval64_timer.sv
module tb_interval64_timer;
  import it64_pkg::*;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          slow_clk_in = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb_q[$];
  logic  re_q = 1'b0;

  always #2.5 clk = ~clk;

  interval64_timer #(.DATA_W(DW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .slow_clk_in (slow_clk_in),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_re      (bus_re),
    .bus_rdata   (bus_rdata),
    .irq         (irq)
  );

  // monitor side of the scoreboard
  always @(posedge clk) begin
    if (!rst_n) re_q <= 1'b0;
    else        re_q <= bus_re;
  end

  always @(negedge clk) begin
    if (re_q) begin
      item_t it;
      checks++;
      if (sb_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data: actual %h expected none", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  // driver tasks, entered and left at a falling edge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DW-1:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DW-1:0] e, input string tag);
    item_t it;
    it.exp = e;
    it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a;
    bus_re   = 1'b1;
    @(negedge clk);
    bus_re   = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s: actual irq %b expected %b", tag, irq, e);
    end
  endtask

  task automatic soft_reset();
    wr(A_CTRL, 16'h0100);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(A_CTRL,   16'h0000, "R1 control");
    rd(A_MODE,   16'h0000, "R1 mode");
    rd(A_PER_LO, 16'hFFFF, "R1 period low");
    rd(A_PER_HI, 16'hFFFF, "R1 period high");
    rd(A_IEN,    16'h0000, "R1 enable");
    rd(A_STAT,   16'h0000, "R1 status");
    rd(A_CNT_LO, 16'h0000, "R1 counter");
    rd(6'h14,    16'h0000, "R1 unmapped");

    // R2: bus clock, divider 0
    wr(A_CTRL, 16'h0001);
    repeat (10) @(negedge clk);
    rd(A_CNT_LO, 16'd10, "R2 count after 10");
    rd(A_CTRL,   16'h0001, "R2 running");
    soft_reset();

    // R3: divider 3 counts every fourth cycle
    wr(A_MODE, 16'h0301);
    wr(A_IEN,  16'h0001);
    wr(A_CTRL, 16'h0001);
    repeat (20) @(negedge clk);
    rd(A_CNT_LO, 16'd5, "R3 divided count");

    // R11: reset bit wins over start in the same write
    wr(A_CTRL, 16'h0101);
    rd(A_CTRL,   16'h0000, "R11 stopped");
    rd(A_MODE,   16'h0000, "R11 mode cleared");
    rd(A_CNT_LO, 16'h0000, "R11 counter cleared");
    rd(A_PER_LO, 16'hFFFF, "R11 period restored");
    rd(A_IEN,    16'h0000, "R11 enable cleared");

    // R6: high word alone is only staged
    wr(A_PER_LO, 16'd5);
    wr(A_PER_HI, 16'h0000);
    wr(A_MODE,   16'h0001);
    wr(A_CTRL,   16'h0001);
    repeat (12) @(negedge clk);
    rd(A_CNT_LO, 16'd12, "R6 no early wrap");
    rd(A_PER_HI, 16'h0000, "R6 staged high readback");
    soft_reset();

    // R4, R8, R9: continuous, period 5
    wr(A_PER_HI, 16'h0000);
    wr(A_PER_LO, 16'd5);
    wr(A_MODE,   16'h0001);
    wr(A_IEN,    16'h0001);
    wr(A_CTRL,   16'h0001);
    repeat (8) @(negedge clk);
    rd(A_CNT_LO, 16'd2, "R4 wrapped count");
    chk_irq(1'b1, "R9 irq raised");
    rd(A_STAT, 16'h0001, "R8 pending read");
    chk_irq(1'b0, "R8 irq after clear");
    rd(A_STAT, 16'h0000, "R8 cleared");
    wr(A_IEN, 16'h0000);
    chk_irq(1'b0, "R9 masked");
    wr(A_IEN, 16'h0001);
    chk_irq(1'b1, "R9 unmasked");
    repeat (4) @(negedge clk);
    rd(A_STAT, 16'h0001, "R8 read on event cycle");
    rd(A_STAT, 16'h0001, "R8 set wins");
    rd(A_STAT, 16'h0000, "R8 cleared after");
    rd(A_CTRL, 16'h0001, "R4 still running");
    soft_reset();

    // R5: single-shot, period 3
    wr(A_PER_HI, 16'h0000);
    wr(A_PER_LO, 16'd3);
    wr(A_MODE,   16'h0000);
    wr(A_CTRL,   16'h0001);
    repeat (21) @(negedge clk);
    rd(A_CNT_LO, 16'd0, "R5 stopped at zero");
    rd(A_CTRL,   16'h0000, "R5 not running");
    rd(A_STAT,   16'h0001, "R5 pending");
    wr(A_CTRL, 16'h0001);
    repeat (2) @(negedge clk);
    rd(A_CNT_LO, 16'd2, "R5 restart");
    soft_reset();

    // R10: slow clock source
    wr(A_MODE, 16'h0009);
    wr(A_CTRL, 16'h0001);
    repeat (10) @(negedge clk);
    rd(A_CNT_LO, 16'd0, "R10 no advance without slow edges");
    for (int i = 0; i < 5; i++) begin
      slow_clk_in = 1'b1;
      repeat (3) @(negedge clk);
      slow_clk_in = 1'b0;
      repeat (3) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    rd(A_CNT_LO, 16'd5, "R10 five slow edges");
    soft_reset();

    // R7: captured high word across a gap
    wr(A_MODE, 16'h0001);
    wr(A_CTRL, 16'h0001);
    repeat (65530) @(negedge clk);
    rd(A_CNT_LO, 16'hFFFA, "R7 low before carry");
    repeat (20) @(negedge clk);
    rd(A_CNT_HI, 16'h0000, "R7 captured high");
    rd(A_CNT_LO, 16'd16, "R7 low after carry");
    rd(A_CNT_HI, 16'h0001, "R7 new high");
    soft_reset();

    repeat (2) @(negedge clk);
    if (sb_q.size() != 0) begin
      checks++;
      fails++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    summary();
    $finish;
  end
endmodule